// File: doc/BRIEF.md
# Priority-Queued Preemptive Crossbar Arbiter

This block is the control half of an M-master by S-slave crossbar. Each master asks for one slave at a time, giving a priority and a transfer length counted in data beats. Every slave has its own arbiter. Requests that are waiting for a slave are kept in priority order, with arrival order breaking ties, and the slave is handed to the request at the head of that order. Data moving through the crossbar is represented only by an ownership (grant) line and a per-beat strobe for each master. No data muxes are modelled.

Each hand-over costs time before data moves. First there are `ovh` arbitration cycles, then `lat` slave access cycles. Both values come from input ports. A request that arrives for a busy slave with strictly higher priority than the current owner takes the slave over. The displaced transfer keeps its remaining beat count and goes back to the front of its own priority level. A global cap limits how many slaves may own a transfer at the same time.

A master raises `req` and holds its target, priority and length steady. It counts the `beat` strobes it receives. It lowers `req` in the cycle in which it sees its one-cycle `done` pulse.

Top module: `xbar_pq_arb`

## Requirements
- R1: A transfer of length L (L >= 1) delivers exactly L `beat` pulses to its master. A single-cycle `done` follows in the cycle after the last beat. `grant` is low while `done` is high, and no beat is lost or repeated when the transfer is suspended.
- R2: Suppose a master raises `req` to an idle slave, and its request is sampled at clock edge k while no other request is pending. Then `grant` is high after edge k+1, and the first `beat` appears after edge k+1+ovh+lat.
- R3: When several requests wait for the same slave, the one with the numerically largest `prio` (larger value means higher priority) is granted first.
- R4: Requests of equal priority are granted in the order they were first sampled. Requests sampled at the same edge are ordered by master index, lowest first.
- R5: A waiting request with strictly higher priority than the current owner of a slave suspends that owner. The new request then starts its ovh+lat wait, with the same timing as in R2 counted from its own sample edge. Preemption does not occur if the owner is in its last beat.
- R6: A waiting request of equal or lower priority never interrupts a transfer. The owner's L beats arrive on consecutive cycles once they start.
- R7: A suspended transfer keeps its remaining beats and resumes before any other waiting request of the same priority, including requests that arrived before it was suspended.
- R8: The ovh+lat wait applies to every grant, including the resumption of a suspended transfer. After an owner's `done`, the next owner's first beat arrives ovh+lat+1 cycles after that `done` cycle.
- R9: At most MAX_ACT slaves own a transfer at once, so `$countones(grant)` never exceeds MAX_ACT. When the cap blocks some idle slaves, lower-numbered slaves are granted first.
- R10: A synchronous `rst` clears all queues, ownerships and beat counters. In the cycle after a reset edge, `grant`, `beat` and `done` are all zero, and a fresh request then receives its full length.
- R11: A master receives a `beat` only while its `grant` is high, and `grant` rises only while its `req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | M | Per-master request, held until `done` |
| slave_id | input | M*SW | Per-master target slave index, SW bits each |
| prio | input | M*PW | Per-master priority, larger wins |
| len | input | M*LW | Per-master transfer length in beats, at least 1 |
| ovh | input | CW | Arbitration overhead cycles per grant |
| lat | input | CW | Slave access cycles per grant |
| grant | output | M | Master currently owns a slave |
| beat | output | M | One data beat delivered to the master this cycle |
| done | output | M | One-cycle pulse after a master's final beat |

## Verification
A corrupted queue order shows up at the ports as `done` pulses in the wrong sequence. This is visible within one transfer length plus ovh+lat cycles of the hand-over. A lost or miscounted remaining-beat value shows as a total beat count that differs from `len` on the master's own strobe. A wrong wait counter shifts the first beat away from the cycle that ovh+lat predicts, so it is caught on the very first grant after it. Sweeping all small overhead, latency and length combinations, together with directed preemption, tie and cap scenarios, checks each of these against cycle counts worked out arithmetically.

// File: rtl/xbar_pq_arb.sv
module xbar_pq_arb #(
  parameter int M = 4,
  parameter int S = 2,
  parameter int PW = 3,
  parameter int LW = 4,
  parameter int CW = 3,
  parameter int MAX_ACT = 2,
  localparam int SW = (S > 1) ? $clog2(S) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [M-1:0]  req,
  input  logic [M*SW-1:0] slave_id,
  input  logic [M*PW-1:0] prio,
  input  logic [M*LW-1:0] len,
  input  logic [CW-1:0] ovh,
  input  logic [CW-1:0] lat,
  output logic [M-1:0]  grant,
  output logic [M-1:0]  beat,
  output logic [M-1:0]  done
);
  localparam int MW = (M > 1) ? $clog2(M) : 1;
  localparam int QW = CW + 1;

  logic [SW-1:0] tgt [M];
  logic [PW-1:0] pr  [M];
  logic [LW-1:0] ln  [M];

  logic [M-1:0]  waiting, owning, done_q;
  logic [LW-1:0] rem   [M];
  logic [M-1:0]  older [M];

  logic [S-1:0]  busy;
  logic [MW-1:0] own  [S];
  logic [QW-1:0] wcnt [S];

  logic [MW-1:0] win [S];
  logic [S-1:0]  new_g, dat, lastb, pre;
  logic [M-1:0]  enq, pre_m, beat_m;

  always_comb begin
    for (int i = 0; i < M; i++) begin
      tgt[i] = slave_id[i*SW +: SW];
      pr[i]  = prio[i*PW +: PW];
      ln[i]  = len[i*LW +: LW];
    end
  end

  always_comb begin
    int taken;
    logic [MW-1:0] w;
    logic hw;
    taken  = 0;
    enq    = req & ~waiting & ~owning & ~done_q;
    pre_m  = '0;
    beat_m = '0;
    for (int s = 0; s < S; s++) begin
      hw = 1'b0;
      w  = '0;
      for (int i = 0; i < M; i++)
        if (waiting[i] && tgt[i] == SW'(s) &&
            (!hw || pr[i] > pr[w] || (pr[i] == pr[w] && older[i][w]))) begin
          hw = 1'b1;
          w  = MW'(i);
        end
      win[s]   = w;
      dat[s]   = busy[s] && wcnt[s] == '0;
      lastb[s] = dat[s] && rem[own[s]] == LW'(1);
      pre[s]   = busy[s] && hw && pr[w] > pr[own[s]] && !lastb[s];
      new_g[s] = !busy[s] && hw && ($countones(busy) + taken < MAX_ACT);
      if (new_g[s]) taken++;
      if (dat[s]) beat_m[own[s]] = 1'b1;
      if (pre[s]) pre_m[own[s]]  = 1'b1;
    end
  end

  assign grant = owning;
  assign beat  = beat_m;
  assign done  = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting <= '0;
      owning  <= '0;
      done_q  <= '0;
      busy    <= '0;
      for (int i = 0; i < M; i++) begin
        rem[i]   <= '0;
        older[i] <= '0;
      end
      for (int s = 0; s < S; s++) begin
        own[s]  <= '0;
        wcnt[s] <= '0;
      end
    end else begin
      done_q <= '0;
      for (int i = 0; i < M; i++) begin
        if (enq[i]) begin
          waiting[i] <= 1'b1;
          rem[i]     <= ln[i];
          for (int j = 0; j < M; j++)
            if (j != i) begin
              older[j][i] <= waiting[j] | pre_m[j] | (enq[j] && j < i);
              older[i][j] <= !(waiting[j] | pre_m[j] | (enq[j] && j < i));
            end
        end
        if (pre_m[i])
          for (int j = 0; j < M; j++)
            if (j != i) begin
              older[i][j] <= 1'b1;
              older[j][i] <= 1'b0;
            end
      end
      for (int s = 0; s < S; s++) begin
        if (busy[s]) begin
          if (!dat[s]) wcnt[s] <= wcnt[s] - QW'(1);
          else rem[own[s]] <= rem[own[s]] - LW'(1);
          if (lastb[s]) begin
            busy[s]         <= 1'b0;
            owning[own[s]]  <= 1'b0;
            done_q[own[s]]  <= 1'b1;
          end else if (pre[s]) begin
            owning[own[s]]  <= 1'b0;
            waiting[own[s]] <= 1'b1;
            own[s]          <= win[s];
            wcnt[s]         <= QW'(ovh) + QW'(lat);
            owning[win[s]]  <= 1'b1;
            waiting[win[s]] <= 1'b0;
          end
        end else if (new_g[s]) begin
          busy[s]         <= 1'b1;
          own[s]          <= win[s];
          wcnt[s]         <= QW'(ovh) + QW'(lat);
          owning[win[s]]  <= 1'b1;
          waiting[win[s]] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/xbar_pq_arb_chk.sv
module xbar_pq_arb_chk #(
  parameter int M = 4,
  parameter int MAX_ACT = 2
) (
  input logic         clk,
  input logic         rst,
  input logic [M-1:0] req,
  input logic [M-1:0] grant,
  input logic [M-1:0] beat,
  input logic [M-1:0] done
);
  p_cap_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(grant) <= MAX_ACT);

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (grant == '0 && beat == '0 && done == '0));

  for (genvar i = 0; i < M; i++) begin : g_m
    p_beat_owned_r11: assert property (@(posedge clk) disable iff (rst)
      beat[i] |-> grant[i]);
    p_grant_needs_req_r11: assert property (@(posedge clk) disable iff (rst)
      $rose(grant[i]) |-> req[i]);
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
      done[i] |=> !done[i]);
    p_done_after_beat_r1: assert property (@(posedge clk) disable iff (rst)
      done[i] |-> ($past(beat[i]) && !grant[i]));
  end
endmodule

bind xbar_pq_arb xbar_pq_arb_chk #(.M(M), .MAX_ACT(MAX_ACT)) u_chk (
  .clk(clk), .rst(rst), .req(req), .grant(grant), .beat(beat), .done(done)
);

// File: tb/test_xbar_pq_arb.sv
module test_xbar_pq_arb;
  localparam int M = 3, S = 2, PW = 2, LW = 3, CW = 2, MAX_ACT = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [M-1:0]    req = '0;
  logic [M-1:0]    slave_id = '0;
  logic [M*PW-1:0] prio = '0;
  logic [M*LW-1:0] len = '0;
  logic [CW-1:0]   ovh = '0, lat = '0;
  logic [M-1:0]    grant, beat, done;

  always #4 clk = ~clk;

  xbar_pq_arb #(.M(M), .S(S), .PW(PW), .LW(LW), .CW(CW), .MAX_ACT(MAX_ACT)) i_xbar_pq_arb (
    .clk(clk), .rst(rst), .req(req), .slave_id(slave_id), .prio(prio), .len(len),
    .ovh(ovh), .lat(lat), .grant(grant), .beat(beat), .done(done)
  );

  int checks = 0, fails = 0, cyc = 0;
  int nb [M], fb [M], dc [M], gr [M];
  int lg [8];
  int nl = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear();
    for (int i = 0; i < M; i++) begin
      nb[i] = 0; fb[i] = -1; dc[i] = -1; gr[i] = -1;
    end
    nl = 0;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    for (int i = 0; i < M; i++) begin
      if (grant[i] && gr[i] < 0) gr[i] = cyc;
      if (beat[i]) begin
        nb[i]++;
        if (fb[i] < 0) fb[i] = cyc;
      end
      if (done[i]) begin
        dc[i] = cyc;
        if (nl < 8) lg[nl] = i;
        nl++;
        req[i] = 1'b0;
      end
    end
  endtask

  task automatic drive(int i, int s, int p, int l);
    slave_id[i]       = s[0];
    prio[i*PW +: PW]  = p[PW-1:0];
    len[i*LW +: LW]   = l[LW-1:0];
    req[i]            = 1'b1;
  endtask

  task automatic wait_idle(string tag);
    int n = 0;
    do begin
      step();
      n++;
    end while ((req != '0 || grant != '0) && n < 400);
    if (n >= 400) begin
      checks++; fails++;
      $display("FAIL %s watchdog actual=%0d expected<400", tag, n);
    end
    step();
  endtask

  task automatic wait_beat(int i, string tag);
    int n = 0;
    while (nb[i] < 1 && n < 400) begin
      step();
      n++;
    end
    if (n >= 400) begin
      checks++; fails++;
      $display("FAIL %s watchdog actual=%0d expected<400", tag, n);
    end
  endtask

  initial begin
    int c, k;
    clear();
    step(); step();
    chk("R10 reset grant", int'(grant), 0);
    chk("R10 reset beat", int'(beat), 0);
    chk("R10 reset done", int'(done), 0);
    rst = 1'b0;
    step();

    // R1 R2 R8: sweep overhead, latency and length
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int l = 1; l <= 4; l++) begin
          int m;
          m = (a + b + l) % M;
          ovh = CW'(a); lat = CW'(b);
          clear();
          c = cyc;
          drive(m, l % S, 1, l);
          wait_idle("R2 sweep");
          chk("R2 grant cycle", gr[m], c + 2);
          chk("R2 first beat cycle", fb[m], c + 2 + a + b);
          chk("R1 beat count", nb[m], l);
          chk("R1 done cycle", dc[m], c + 2 + a + b + l);
        end

    ovh = 2'd1; lat = 2'd1;
    // R4: same-cycle arrivals, lower index first
    clear();
    drive(2, 0, 1, 2); drive(0, 0, 1, 2); drive(1, 0, 1, 2);
    wait_idle("R4 same cycle");
    chk("R4 order0", lg[0], 0); chk("R4 order1", lg[1], 1); chk("R4 order2", lg[2], 2);

    // R4: arrival order across cycles
    clear();
    drive(2, 0, 1, 2); step(); drive(0, 0, 1, 2); step(); drive(1, 0, 1, 2);
    wait_idle("R4 arrival");
    chk("R4 arrival0", lg[0], 2); chk("R4 arrival1", lg[1], 0); chk("R4 arrival2", lg[2], 1);

    // R3: priority order among waiting requests
    clear();
    drive(0, 1, 1, 2); drive(1, 1, 3, 2); drive(2, 1, 2, 2);
    wait_idle("R3");
    chk("R3 order0", lg[0], 1); chk("R3 order1", lg[1], 2); chk("R3 order2", lg[2], 0);

    // R5 R8: preemption and resumption timing
    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++) begin
        ovh = CW'(a); lat = CW'(b);
        clear();
        drive(0, 0, 1, 4);
        wait_beat(0, "R5");
        c = cyc;
        drive(1, 0, 2, 2);
        while (dc[1] < 0 && cyc < c + 100) step();
        k = nb[0];
        wait_idle("R5");
        chk("R5 preemptor first beat", fb[1], c + 2 + a + b);
        chk("R5 order first", lg[0], 1);
        chk("R5 order second", lg[1], 0);
        chk("R1 suspended beats total", nb[0], 4);
        chk("R8 resume done cycle", dc[0], dc[1] + 1 + a + b + 4 - k);
      end

    ovh = 2'd1; lat = 2'd1;
    // R6: equal priority does not preempt
    clear();
    drive(0, 0, 1, 3);
    wait_beat(0, "R6");
    drive(1, 0, 1, 1);
    wait_idle("R6");
    chk("R6 order", lg[0], 0);
    chk("R6 contiguous beats", dc[0] - fb[0], 3);

    // R7: suspended owner resumes ahead of older equal-priority waiter
    clear();
    drive(0, 1, 1, 4);
    wait_beat(0, "R7");
    drive(2, 1, 1, 1);
    step();
    drive(1, 1, 3, 1);
    wait_idle("R7");
    chk("R7 order0", lg[0], 1); chk("R7 order1", lg[1], 0); chk("R7 order2", lg[2], 2);
    chk("R7 remaining beats kept", nb[0], 4);

    // R9: cap of one active slave, lower slave index first
    clear();
    c = cyc;
    drive(0, 1, 1, 2); drive(1, 0, 1, 2);
    wait_idle("R9");
    chk("R9 slave0 first beat", fb[1], c + 4);
    chk("R9 slave1 waits for cap", fb[0], dc[1] + 3);
    chk("R9 order", lg[0], 1);

    // R10: reset mid-transfer
    clear();
    drive(0, 0, 1, 4);
    wait_beat(0, "R10");
    rst = 1'b1; req = '0;
    step(); step();
    chk("R10 mid grant", int'(grant), 0);
    chk("R10 mid beat", int'(beat), 0);
    chk("R10 mid done", int'(done), 0);
    rst = 1'b0;
    step();
    clear();
    drive(0, 0, 1, 4);
    wait_idle("R10 fresh");
    chk("R10 fresh full length", nb[0], 4);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule